// File: doc/BRIEF.md
# Push-Pull Gate Drive Timing Generator

This block creates the two alternating gate-drive signals for a push-pull power stage. A digital sawtooth counter plays the part of the high-frequency ramp. Each ramp cycle holds exactly one drive pulse. That pulse begins when the counter is at zero and ends when the counter reaches the duty code. Successive pulses go to output A and output B in turn. As a result, each output runs at half the ramp rate, and the two outputs are half a period apart.

The duty code comes from the error-amplifier side. The ramp period and the dead-time come from configuration. A disable line from the protection sequencer pulls both outputs low at once. When disable drops again, pulsing resumes only at the next ramp boundary, and always starts on output A. A one-clock tick marks the first clock of every ramp cycle, so that an overvoltage persistence counter elsewhere can count ramp cycles.

The default counter is 11 bits wide, which covers 250 to 2000 clocks per ramp. At a 100 MHz clock that is the 400 kHz to 50 kHz ramp range.

Top module: `pp_drive`

## Requirements
- R1: The ramp counter runs from 0 up to the period code P and then wraps, so one ramp cycle lasts P+1 clocks. The tick output is high for exactly the first clock of each ramp cycle, when the counter is 0. P is sampled only at a wrap, so a change made in mid-cycle first affects the following cycle.
- R2: Pulses alternate between output A and output B on successive ramp cycles. The first pulse after enable is always on output A. Each output therefore repeats every 2(P+1) clocks.
- R3: Output A and output B are never high in the same clock.
- R4: A pulse rises in the clock where the counter is 0. It lasts min(D, P+1-G) clocks, where D is the duty code and G is the guard interval. If P+1-G is zero or less, there is no pulse. G equals the dead-time code, except that a code of 0 gives G = 1. Each output's duty is therefore strictly below 50%.
- R5: Between one output going low and the other output going high there are at least G clocks with both outputs low.
- R6: The duty and dead-time codes are sampled only at a wrap. Changing them in mid-cycle does not alter the pulse of the current cycle.
- R7: During reset both outputs and the tick are low. The first ramp cycle after reset is idle. The first pulse appears on A in the ramp cycle that follows the first wrap.
- R8: While disable is high, both outputs are low. This takes effect in the same clock in which disable is raised.
- R9: After disable is released, the outputs stay low until the next wrap. If disable is released in the clock where the counter equals P, the pulse on A begins in the very next clock, together with the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| disable_i | input | 1 | Global drive shutdown from the protection sequencer |
| period_i | input | CNT_W | Ramp period code P (cycle length P+1 clocks) |
| duty_i | input | CNT_W | Pulse width request in clocks (duty code D) |
| dead_i | input | DT_W | Minimum low gap between the outputs, in clocks (0 means 1) |
| drv_a_o | output | 1 | Gate drive for output A |
| drv_b_o | output | 1 | Gate drive for output B |
| tick_o | output | 1 | One-clock marker at the start of each ramp cycle |

## Verification
Two events can fall on the same clock: the ramp wrap, which samples new codes and advances the output selection, and the release of disable. The bench provokes this collision by timing the release from the tick, so that disable drops exactly when the counter equals P. It then requires the tick and a full-width pulse on A in the next clock. A second collision is a code change made in the clock of a tick. That change must leave the running cycle's length and pulse untouched, and must shape only the following cycle. The bench judges this by counting cycle length and high clocks on each side.

// File: rtl/pp_pkg.sv
package pp_pkg;

    // Width of the pulse-limit arithmetic; counter widths up to CALC_W-1 are supported.
    localparam int unsigned CALC_W = 17;

    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;

    // Clamp the requested pulse so that at least one guard interval stays low.
    function automatic logic [CALC_W-1:0] pulse_limit(
        input logic [CALC_W-1:0] ramp_len,
        input logic [CALC_W-1:0] duty,
        input logic [CALC_W-1:0] dead_code
    );
        logic [CALC_W-1:0] guard;
        logic [CALC_W-1:0] room;
        guard = (dead_code == '0) ? CALC_W'(1) : dead_code;
        room  = (ramp_len > guard) ? (ramp_len - guard) : '0;
        return (duty < room) ? duty : room;
    endfunction

endpackage

// File: rtl/pp_ramp.sv
module pp_ramp #(
    parameter int unsigned CNT_W = 11,
    parameter int unsigned DT_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [CNT_W-1:0]            period_i,
    input  logic [CNT_W-1:0]            duty_i,
    input  logic [DT_W-1:0]             dead_i,
    output logic [CNT_W-1:0]            cnt_o,
    output logic                        wrap_o,
    output logic [pp_pkg::CALC_W-1:0]   lim_o,
    output logic                        tick_o
);
    import pp_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] duty_q;
    logic [DT_W-1:0]  dead_q;
    logic             tick_q;
    logic             wrap;

    assign wrap = (cnt_q == per_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            per_q  <= period_i;
            duty_q <= duty_i;
            dead_q <= dead_i;
            tick_q <= 1'b0;
        end else begin
            tick_q <= wrap;
            if (wrap) begin
                cnt_q  <= '0;
                per_q  <= period_i;
                duty_q <= duty_i;
                dead_q <= dead_i;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    always_comb begin
        lim_o = pulse_limit(CALC_W'(per_q) + CALC_W'(1), CALC_W'(duty_q), CALC_W'(dead_q));
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = wrap;
    assign tick_o = tick_q;

    // R1: the tick marks the first clock of a ramp cycle
    a_r1_tick_at_zero: assert property (@(posedge clk) disable iff (rst)
        tick_q |-> (cnt_q == '0));

endmodule

// File: rtl/pp_steer.sv
module pp_steer #(
    parameter int unsigned CNT_W = 11
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        disable_i,
    input  logic [CNT_W-1:0]            cnt_i,
    input  logic                        wrap_i,
    input  logic [pp_pkg::CALC_W-1:0]   lim_i,
    output logic [1:0]                  drv_o
);
    import pp_pkg::*;

    side_e side_q;
    logic  en_q;
    logic  in_pulse;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            side_q <= SIDE_A;
        end else begin
            if (wrap_i) begin
                if (!en_q) begin
                    side_q <= SIDE_A;
                end else begin
                    side_q <= (side_q == SIDE_A) ? SIDE_B : SIDE_A;
                end
            end
            if (disable_i) begin
                en_q <= 1'b0;
            end else if (wrap_i) begin
                en_q <= 1'b1;
            end
        end
    end

    assign in_pulse = (CALC_W'(cnt_i) < lim_i);

    for (genvar s = 0; s < 2; s++) begin : g_side
        localparam side_e MY_SIDE = (s == 0) ? SIDE_A : SIDE_B;
        assign drv_o[s] = en_q && !disable_i && in_pulse && (side_q == MY_SIDE);
    end

    // R9: enabling only happens on a ramp boundary
    a_r9_enable_at_boundary: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> (cnt_i == '0));

    // R4: any rising drive edge lands on counter zero
    a_r4_rise_at_zero: assert property (@(posedge clk) disable iff (rst)
        ($rose(drv_o[0]) || $rose(drv_o[1])) |-> (cnt_i == '0));

endmodule

// File: rtl/pp_drive.sv
module pp_drive #(
    parameter int unsigned CNT_W = 11,
    parameter int unsigned DT_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             disable_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    input  logic [DT_W-1:0]  dead_i,
    output logic             drv_a_o,
    output logic             drv_b_o,
    output logic             tick_o
);
    import pp_pkg::*;

    logic [CNT_W-1:0]  cnt;
    logic              wrap;
    logic [CALC_W-1:0] lim;
    logic [1:0]        drv;

    pp_ramp #(.CNT_W(CNT_W), .DT_W(DT_W)) i_ramp (
        .clk      (clk),
        .rst      (rst),
        .period_i (period_i),
        .duty_i   (duty_i),
        .dead_i   (dead_i),
        .cnt_o    (cnt),
        .wrap_o   (wrap),
        .lim_o    (lim),
        .tick_o   (tick_o)
    );

    pp_steer #(.CNT_W(CNT_W)) i_steer (
        .clk       (clk),
        .rst       (rst),
        .disable_i (disable_i),
        .cnt_i     (cnt),
        .wrap_i    (wrap),
        .lim_i     (lim),
        .drv_o     (drv)
    );

    assign drv_a_o = drv[0];
    assign drv_b_o = drv[1];

    // R3: never both on
    a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(drv_a_o && drv_b_o));

    // R5: the clock in which one side drops has the other side still low
    a_r5_gap_after_a: assert property (@(posedge clk) disable iff (rst)
        $fell(drv_a_o) |-> !drv_b_o);
    a_r5_gap_after_b: assert property (@(posedge clk) disable iff (rst)
        $fell(drv_b_o) |-> !drv_a_o);

    // R7: the cycle after a reset clock is idle
    a_r7_idle_after_reset: assert property (@(posedge clk)
        rst |=> (!drv_a_o && !drv_b_o));

endmodule

// File: tb/test_pp_drive.sv
module test_pp_drive;

    localparam int CLK_NS = 10;
    localparam int CNT_W  = 11;
    localparam int DT_W   = 4;
    localparam int NV     = 7;

    // period, duty, dead
    localparam int VEC [NV][3] = '{
        '{9,    3,    2},
        '{9,    20,   2},
        '{9,    20,   0},
        '{15,   0,    3},
        '{4,    2,    7},
        '{249,  100,  5},
        '{1999, 1500, 10}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             disable_i = 1'b0;
    logic [CNT_W-1:0] period_i = '0;
    logic [CNT_W-1:0] duty_i = '0;
    logic [DT_W-1:0]  dead_i = '0;
    logic             drv_a_o, drv_b_o, tick_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    pp_drive #(.CNT_W(CNT_W), .DT_W(DT_W)) i_pp_drive (
        .clk(clk), .rst(rst), .disable_i(disable_i),
        .period_i(period_i), .duty_i(duty_i), .dead_i(dead_i),
        .drv_a_o(drv_a_o), .drv_b_o(drv_b_o), .tick_o(tick_o)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic int exp_lim(input int per, input int duty, input int dead);
        int len, g, room;
        len  = per + 1;
        g    = (dead == 0) ? 1 : dead;
        room = (len > g) ? len - g : 0;
        return (duty < room) ? duty : room;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input int per, input int duty, input int dead);
        period_i = CNT_W'(per);
        duty_i   = CNT_W'(duty);
        dead_i   = DT_W'(dead);
    endtask

    // Reset for one clock, check idle outputs (R7), release on a falling edge.
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!drv_a_o && !drv_b_o && !tick_o, "R7", "outputs in reset",
              int'({drv_a_o, drv_b_o, tick_o}), 0);
        rst = 1'b0;
    endtask

    task automatic wait_tick();
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (tick_o) break;
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int per, duty, dead, len, lim, w, geff;
        int ticks, bad_tick, a_cnt, b_cnt, both, first_rise, last_fall;
        int min_gap, max_gap, cnt;
        bit prev_a, prev_b, ok;

        // ---------------- vector table walk ----------------
        for (int v = 0; v < NV; v++) begin
            per = VEC[v][0]; duty = VEC[v][1]; dead = VEC[v][2];
            len = per + 1;
            lim = exp_lim(per, duty, dead);
            geff = (dead == 0) ? 1 : dead;
            w = 5 * len - 1;
            set_cfg(per, duty, dead);
            disable_i = 1'b0;
            do_reset();
            ticks = 0; bad_tick = 0; a_cnt = 0; b_cnt = 0; both = 0;
            first_rise = -1; last_fall = -1; min_gap = 1 << 30; max_gap = -1;
            prev_a = 1'b0; prev_b = 1'b0;
            for (int s = 1; s <= w; s++) begin
                @(negedge clk);
                if (tick_o) begin
                    ticks++;
                    if ((s % len) != 0) bad_tick++;
                end
                if (drv_a_o) a_cnt++;
                if (drv_b_o) b_cnt++;
                if (drv_a_o && drv_b_o) both++;
                if (drv_a_o && !prev_a && first_rise < 0) first_rise = s;
                if (((drv_a_o && !prev_a) || (drv_b_o && !prev_b)) && last_fall >= 0) begin
                    if (s - last_fall < min_gap) min_gap = s - last_fall;
                    if (s - last_fall > max_gap) max_gap = s - last_fall;
                end
                if ((prev_a && !drv_a_o) || (prev_b && !drv_b_o)) last_fall = s;
                prev_a = drv_a_o;
                prev_b = drv_b_o;
            end
            check(ticks == 4, "R1", "tick count", ticks, 4);
            check(bad_tick == 0, "R1", "misplaced ticks", bad_tick, 0);
            check(a_cnt == 2 * lim, "R4", "A high clocks", a_cnt, 2 * lim);
            check(b_cnt == 2 * lim, "R2", "B high clocks", b_cnt, 2 * lim);
            check(both == 0, "R3", "overlap clocks", both, 0);
            if (lim > 0) begin
                check(first_rise == len, "R7", "first A rise sample", first_rise, len);
                check(min_gap == len - lim && max_gap == len - lim, "R5",
                      "gap between sides", min_gap, len - lim);
                check(min_gap >= geff, "R5", "gap vs guard", min_gap, geff);
            end
        end

        // ---------------- disable forces low, release waits for boundary ----------------
        set_cfg(9, 3, 2);
        disable_i = 1'b0;
        do_reset();
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (drv_a_o) break;
        end
        disable_i = 1'b1;
        #1;
        check(!drv_a_o && !drv_b_o, "R8", "outputs same clock as disable",
              int'({drv_a_o, drv_b_o}), 0);
        cnt = 0;
        for (int k = 0; k < 25; k++) begin
            @(negedge clk);
            if (drv_a_o || drv_b_o) cnt++;
        end
        check(cnt == 0, "R8", "high clocks while disabled", cnt, 0);
        wait_tick();
        repeat (4) @(negedge clk);
        disable_i = 1'b0;
        cnt = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (tick_o) break;
            if (drv_a_o || drv_b_o) cnt++;
        end
        check(cnt == 0, "R9", "high clocks before boundary", cnt, 0);
        check(drv_a_o && !drv_b_o, "R9", "A first at boundary",
              int'({drv_a_o, drv_b_o}), 2);
        cnt = drv_a_o ? 1 : 0;
        repeat (9) begin
            @(negedge clk);
            if (drv_a_o) cnt++;
        end
        check(cnt == 3, "R9", "first pulse width after release", cnt, 3);

        // ---------------- release in the wrap clock ----------------
        disable_i = 1'b1;
        wait_tick();
        repeat (9) @(negedge clk);
        disable_i = 1'b0;
        @(negedge clk);
        ok = tick_o && drv_a_o && !drv_b_o;
        check(ok, "R9", "tick and A right after wrap release",
              int'({tick_o, drv_a_o, drv_b_o}), 6);

        // ---------------- mid-cycle code change (shadowing) ----------------
        set_cfg(9, 3, 2);
        disable_i = 1'b0;
        do_reset();
        repeat (10) @(negedge clk);
        check(tick_o && drv_a_o, "R2", "first enabled cycle on A",
              int'({tick_o, drv_a_o}), 3);
        set_cfg(14, 6, 2);
        a_cnt = drv_a_o ? 1 : 0;
        len = 1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (tick_o) break;
            len++;
            if (drv_a_o) a_cnt++;
        end
        check(len == 10, "R1", "cycle length after mid-cycle period change", len, 10);
        check(a_cnt == 3, "R6", "A width after mid-cycle duty change", a_cnt, 3);
        b_cnt = drv_b_o ? 1 : 0;
        len = 1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (tick_o) break;
            len++;
            if (drv_b_o) b_cnt++;
        end
        check(len == 15, "R1", "next cycle length uses new period", len, 15);
        check(b_cnt == exp_lim(14, 6, 2), "R6", "B width uses new duty", b_cnt, exp_lim(14, 6, 2));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule